// File: doc/BRIEF.md
# Lockable Round-Robin Translation Lookaside Buffer

This block caches address translations produced by a page-table walker in a small fully associative array. A lookup presents a virtual address together with the current process number. Addresses in the lowest 32MB are first relocated into a per-process window: the top seven address bits are replaced by the process number. The resulting modified address is compared against every stored entry, each of which covers a region of 1MB, 64KB, 4KB or 1KB. On a hit the physical address is returned one cycle later. On a miss the block flags the miss, and the walker then writes the translation back through the fill port.

Victims are chosen by a cyclic pointer. A lock count marks the lowest entries as pinned. The pointer never selects a pinned entry and wraps from the last entry back to the first unpinned one. To pin translations, software clears the lock count, fills the wanted entries (the pointer starts at entry 0) and then raises the lock count. A global flush keeps the pinned entries, while an address-directed flush removes any entry covering that address.

Top module: `tlb_rr_lock`

## Requirements
- R1: After reset no entry is valid, so every lookup misses; `rsp_valid`, `rsp_hit` and `rsp_miss` are low until a lookup is made.
- R2: When lookup address bits [31:25] are all zero, the modified address is the 7-bit process number followed by address bits [24:0]; otherwise the modified address equals the lookup address.
- R3: Size code 0 covers 1MB, 1 covers 64KB, 2 covers 4KB and 3 covers 1KB, so the offsets are 20, 16, 12 and 10 bits wide. An entry matches when the modified address and the stored tag agree above the offset. The result takes the stored physical base above the offset and the modified address within it.
- R4: A lookup requested in one cycle gives `rsp_valid` in the next cycle, with either `rsp_hit` and the translated address or `rsp_miss` with `rsp_pa` zero.
- R5: Each accepted fill writes the entry chosen by the cyclic pointer and advances the pointer by one. The pointer starts at entry 0 after reset.
- R6: The pointer wraps from entry 63 to entry `lock_cnt`. A pointer below `lock_cnt` is moved up to `lock_cnt`, so fills never overwrite entries 0 to `lock_cnt`-1.
- R7: Flush-all clears every entry at index `lock_cnt` or above and leaves the pinned entries valid.
- R8: Flush-by-address clears every valid entry whose region contains `inv_mva`, whether pinned or not.
- R9: Commands have the priority flush-all, then flush-by-address, then fill. A fill in a cycle that also has a flush is dropped and does not advance the pointer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lk_req | input | 1 | Lookup request |
| lk_va | input | 32 | Lookup virtual address |
| lk_pid | input | 7 | Current process number |
| rsp_valid | output | 1 | Lookup response present |
| rsp_hit | output | 1 | Lookup hit |
| rsp_miss | output | 1 | Lookup missed |
| rsp_pa | output | 32 | Translated physical address |
| fill_en | input | 1 | Write a translation from the walker |
| fill_mva | input | 32 | Modified address of the fill |
| fill_pa | input | 32 | Physical base of the fill |
| fill_size | input | 2 | Region size code of the fill |
| inv_all | input | 1 | Flush all unpinned entries |
| inv_one | input | 1 | Flush entries covering `inv_mva` |
| inv_mva | input | 32 | Modified address for the directed flush |
| lock_cnt | input | 6 | Number of pinned entries from entry 0 |

## Verification
The bench looks up addresses on both sides of each size boundary. A design that masked the wrong number of offset bits would hit addresses outside the region or return a wrong offset. It uses process numbers on low and high addresses, which catches relocation applied to the wrong range or not applied at all. It fills past entry 63 so the pointer wraps onto `lock_cnt` and then evicts the oldest unpinned entry. A pointer that wrapped to 0 would destroy pinned translations, and one that skipped an entry would leave a stale entry resident. It also checks that a flush-all spares pinned entries, that a flush-by-address removes a pinned one, and that a fill colliding with a flush leaves both the array and the pointer unchanged.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
   localparam int ADDR_W = 32;

   typedef enum logic [1:0] {
      SZ_1M  = 2'd0,
      SZ_64K = 2'd1,
      SZ_4K  = 2'd2,
      SZ_1K  = 2'd3
   } pg_size_e;

   // Offset bits (inside the region) for a given size code
   function automatic logic [ADDR_W-1:0] pg_offset_mask(pg_size_e sz);
      case (sz)
         SZ_1M:   return ADDR_W'((64'd1 << 20) - 1);
         SZ_64K:  return ADDR_W'((64'd1 << 16) - 1);
         SZ_4K:   return ADDR_W'((64'd1 << 12) - 1);
         default: return ADDR_W'((64'd1 << 10) - 1);
      endcase
   endfunction
endpackage

// File: rtl/tlb_pid_reloc.sv
module tlb_pid_reloc
   import tlb_pkg::*;
#(
   parameter int PID_W = 7
) (
   input  logic [ADDR_W-1:0] va,
   input  logic [PID_W-1:0]  pid,
   output logic [ADDR_W-1:0] mva
);
   localparam int LOW_W = ADDR_W - PID_W;

   always_comb begin
      if (va[ADDR_W-1:LOW_W] == '0)
         mva = {pid, va[LOW_W-1:0]};
      else
         mva = va;
   end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
   parameter int ENTRIES = 64,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   input  logic [IDX_W-1:0] lock_cnt,
   output logic [IDX_W-1:0] victim
);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

   logic [IDX_W-1:0] ptr_q;

   assign victim = (ptr_q < lock_cnt) ? lock_cnt : ptr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ptr_q <= '0;
      else if (adv)
         ptr_q <= (victim == LAST) ? lock_cnt : victim + 1'b1;
   end

   // R6: with a steady lock count, the pointer is never left inside the pinned range
   a_r6_ptr_above_lock: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && $stable(lock_cnt)) |=> (ptr_q >= lock_cnt));
endmodule

// File: rtl/tlb_entry_store.sv
module tlb_entry_store
   import tlb_pkg::*;
#(
   parameter int ENTRIES = 64,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] lk_mva,
   output logic              hit_any,
   output logic [ADDR_W-1:0] hit_pa,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [ADDR_W-1:0] wr_mva,
   input  logic [ADDR_W-1:0] wr_pa,
   input  pg_size_e          wr_size,
   input  logic              inv_all,
   input  logic              inv_one,
   input  logic [ADDR_W-1:0] inv_mva,
   input  logic [IDX_W-1:0]  lock_cnt
);
   logic [ENTRIES-1:0] valid_q;
   logic [ADDR_W-1:0]  tag_q [ENTRIES];
   logic [ADDR_W-1:0]  pa_q  [ENTRIES];
   pg_size_e           sz_q  [ENTRIES];
   logic [ADDR_W-1:0]  msk   [ENTRIES];
   logic [ENTRIES-1:0] lk_hit, inv_hit;

   for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
      assign msk[g]     = pg_offset_mask(sz_q[g]);
      assign lk_hit[g]  = valid_q[g] && (((tag_q[g] ^ lk_mva)  & ~msk[g]) == '0);
      assign inv_hit[g] = valid_q[g] && (((tag_q[g] ^ inv_mva) & ~msk[g]) == '0);
   end

   // Lowest-index match wins if regions ever overlap
   logic [IDX_W-1:0] sel;
   always_comb begin
      sel = '0;
      for (int i = ENTRIES - 1; i >= 0; i--)
         if (lk_hit[i]) sel = IDX_W'(i);
   end

   assign hit_any = |lk_hit;
   assign hit_pa  = (pa_q[sel] & ~msk[sel]) | (lk_mva & msk[sel]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         valid_q <= '0;
      else if (inv_all) begin
         for (int i = 0; i < ENTRIES; i++)
            if (IDX_W'(i) >= lock_cnt) valid_q[i] <= 1'b0;
      end else if (inv_one)
         valid_q <= valid_q & ~inv_hit;
      else if (wr_en)
         valid_q[wr_idx] <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (wr_en && !inv_all && !inv_one) begin
         tag_q[wr_idx] <= wr_mva & ~pg_offset_mask(wr_size);
         pa_q[wr_idx]  <= wr_pa  & ~pg_offset_mask(wr_size);
         sz_q[wr_idx]  <= wr_size;
      end
   end

   // R7: after a flush-all nothing at or above the lock count stays valid
   a_r7_flush_spares_pins: assert property (@(posedge clk) disable iff (!rst_n)
      inv_all |=> ((valid_q >> $past(lock_cnt)) == '0));
   // R5: an accepted fill leaves its target entry valid
   a_r5_fill_sets_valid: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !inv_all && !inv_one) |=> valid_q[$past(wr_idx)]);
   // R6: the victim index handed in is never a pinned entry
   a_r6_fill_not_pinned: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (wr_idx >= lock_cnt));
endmodule

// File: rtl/tlb_rr_lock.sv
module tlb_rr_lock
   import tlb_pkg::*;
#(
   parameter int ENTRIES = 64,
   parameter int PID_W   = 7,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lk_req,
   input  logic [ADDR_W-1:0] lk_va,
   input  logic [PID_W-1:0]  lk_pid,
   output logic              rsp_valid,
   output logic              rsp_hit,
   output logic              rsp_miss,
   output logic [ADDR_W-1:0] rsp_pa,
   input  logic              fill_en,
   input  logic [ADDR_W-1:0] fill_mva,
   input  logic [ADDR_W-1:0] fill_pa,
   input  logic [1:0]        fill_size,
   input  logic              inv_all,
   input  logic              inv_one,
   input  logic [ADDR_W-1:0] inv_mva,
   input  logic [IDX_W-1:0]  lock_cnt
);
   if (ENTRIES < 2 || (ENTRIES & (ENTRIES - 1)) != 0) begin : g_bad_entries
      $error("ENTRIES must be a power of two of at least 2");
   end
   if (PID_W < 1 || PID_W > ADDR_W - 20) begin : g_bad_pid
      $error("PID_W must leave room for the largest page offset");
   end

   logic [ADDR_W-1:0] lk_mva, hit_pa;
   logic              hit_any, fill_go;
   logic [IDX_W-1:0]  victim;

   assign fill_go = fill_en && !inv_all && !inv_one;

   tlb_pid_reloc #(.PID_W(PID_W)) u_reloc (
      .va(lk_va), .pid(lk_pid), .mva(lk_mva)
   );

   tlb_victim #(.ENTRIES(ENTRIES)) u_victim (
      .clk(clk), .rst_n(rst_n), .adv(fill_go),
      .lock_cnt(lock_cnt), .victim(victim)
   );

   tlb_entry_store #(.ENTRIES(ENTRIES)) u_store (
      .clk(clk), .rst_n(rst_n),
      .lk_mva(lk_mva), .hit_any(hit_any), .hit_pa(hit_pa),
      .wr_en(fill_go), .wr_idx(victim), .wr_mva(fill_mva),
      .wr_pa(fill_pa), .wr_size(pg_size_e'(fill_size)),
      .inv_all(inv_all), .inv_one(inv_one), .inv_mva(inv_mva),
      .lock_cnt(lock_cnt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_hit   <= 1'b0;
         rsp_miss  <= 1'b0;
         rsp_pa    <= '0;
      end else begin
         rsp_valid <= lk_req;
         rsp_hit   <= lk_req && hit_any;
         rsp_miss  <= lk_req && !hit_any;
         rsp_pa    <= (lk_req && hit_any) ? hit_pa : '0;
      end
   end

   // R4: hit and miss flags are exclusive and only appear with a response
   a_r4_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(rsp_hit && rsp_miss));
   a_r4_flags_need_rsp: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_valid |-> (!rsp_hit && !rsp_miss && rsp_pa == '0));
endmodule

// File: tb/tlb_rr_lock_tb.sv
`timescale 1ns/1ps
module tlb_rr_lock_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lk_req = 1'b0;
   logic [31:0] lk_va = '0;
   logic [6:0]  lk_pid = '0;
   logic        rsp_valid, rsp_hit, rsp_miss;
   logic [31:0] rsp_pa;
   logic        fill_en = 1'b0;
   logic [31:0] fill_mva = '0, fill_pa = '0;
   logic [1:0]  fill_size = '0;
   logic        inv_all = 1'b0, inv_one = 1'b0;
   logic [31:0] inv_mva = '0;
   logic [5:0]  lock_cnt = '0;

   int n_chk = 0, n_bad = 0, cyc = 0;

   always #5 clk = ~clk;

   tlb_rr_lock u_dut (
      .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_va(lk_va), .lk_pid(lk_pid),
      .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_pa(rsp_pa),
      .fill_en(fill_en), .fill_mva(fill_mva), .fill_pa(fill_pa), .fill_size(fill_size),
      .inv_all(inv_all), .inv_one(inv_one), .inv_mva(inv_mva), .lock_cnt(lock_cnt)
   );

   typedef struct packed {
      logic [31:0] va;
      logic [6:0]  pid;
      logic        hit;
      logic [31:0] pa;
   } vec_t;

   // Lookups after filling four entries of different sizes (R2, R3)
   localparam vec_t VECS [9] = '{
      '{32'hA0012345, 7'd0,   1'b1, 32'h56012345},  // 1MB
      '{32'hB001ABCD, 7'd5,   1'b1, 32'h3004ABCD},  // 64KB, high address keeps va
      '{32'hB002ABCD, 7'd0,   1'b0, 32'h00000000},  // next 64KB region
      '{32'h00003123, 7'd2,   1'b1, 32'h33001123},  // relocated by pid 2
      '{32'h00003123, 7'd3,   1'b0, 32'h00000000},  // other pid misses
      '{32'h04003123, 7'd7,   1'b1, 32'h33001123},  // not low: pid ignored
      '{32'hC00007FF, 7'd0,   1'b1, 32'h31000BFF},  // top of 1KB page
      '{32'hC0000800, 7'd0,   1'b0, 32'h00000000},  // just past it
      '{32'h01FFFFFF, 7'h7F,  1'b0, 32'h00000000}   // relocates to all ones
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   // Lookup; response sampled at the negedge after the registering edge (R4)
   task automatic look(input string req, input logic [31:0] va, input logic [6:0] pid,
                       input logic exp_hit, input logic [31:0] exp_pa);
      @(negedge clk);
      lk_req = 1'b1; lk_va = va; lk_pid = pid;
      @(negedge clk);
      lk_req = 1'b0;
      chk({req, " valid"}, 32'(rsp_valid), 32'd1);
      chk({req, " hit"},   32'(rsp_hit),   32'(exp_hit));
      chk({req, " miss"},  32'(rsp_miss),  32'(!exp_hit));
      chk({req, " pa"},    rsp_pa,         exp_pa);
   endtask

   task automatic fill(input logic [31:0] mva, input logic [31:0] pa, input logic [1:0] sz);
      @(negedge clk);
      fill_en = 1'b1; fill_mva = mva; fill_pa = pa; fill_size = sz;
      @(negedge clk);
      fill_en = 1'b0;
   endtask

   task automatic flush(input logic all, input logic [31:0] mva);
      @(negedge clk);
      inv_all = all; inv_one = !all; inv_mva = mva;
      @(negedge clk);
      inv_all = 1'b0; inv_one = 1'b0;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog act=%0d exp=done", cyc);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      chk("R1 rsp_valid after reset", 32'(rsp_valid), 32'd0);
      look("R1 empty lookup", 32'h12345678, 7'd0, 1'b0, 32'h0);

      // R5: entries 0..3 from the pointer starting at 0
      fill(32'hA0000000, 32'h56000000, 2'd0);
      fill(32'hB0010000, 32'h30040000, 2'd1);
      fill(32'h04003000, 32'h33001000, 2'd2);
      fill(32'hC0000400, 32'h31000800, 2'd3);

      for (int k = 0; k < 9; k++)
         look($sformatf("R3 vector %0d", k), VECS[k].va, VECS[k].pid, VECS[k].hit, VECS[k].pa);

      // R7: pin entries 0 and 1, flush all
      lock_cnt = 6'd2;
      flush(1'b1, 32'h0);
      look("R7 pinned 1MB kept",  32'hA0000001, 7'd0, 1'b1, 32'h56000001);
      look("R7 pinned 64KB kept", 32'hB0010002, 7'd0, 1'b1, 32'h30040002);
      look("R7 4KB flushed",      32'h04003000, 7'd0, 1'b0, 32'h0);
      look("R7 1KB flushed",      32'hC0000400, 7'd0, 1'b0, 32'h0);

      // R6: fill entries 4..63, then wrap to lock_cnt
      for (int i = 0; i < 60; i++)
         fill(32'h80000000 + 32'(i) * 32'h400, 32'h20000000 + 32'(i) * 32'h400, 2'd3);
      fill(32'h90000000, 32'h10000000, 2'd0);   // entry 2
      fill(32'h91000000, 32'h11000000, 2'd0);   // entry 3
      look("R6 wrap into entry 2", 32'h90000010, 7'd0, 1'b1, 32'h10000010);
      look("R6 entry 4 still held", 32'h80000000, 7'd0, 1'b1, 32'h20000000);
      fill(32'h92000000, 32'h12000000, 2'd0);   // entry 4, evicts oldest
      look("R6 oldest evicted",     32'h80000000, 7'd0, 1'b0, 32'h0);
      look("R5 next oldest kept",   32'h80000410, 7'd0, 1'b1, 32'h20000410);
      look("R5 newest present",     32'h920ABCDE, 7'd0, 1'b1, 32'h120ABCDE);
      look("R6 pinned survives",    32'hA00FFFFF, 7'd0, 1'b1, 32'h560FFFFF);

      // R9: fill colliding with a directed flush is dropped
      @(negedge clk);
      inv_one = 1'b1; inv_mva = 32'h91080000;
      fill_en = 1'b1; fill_mva = 32'h93000000; fill_pa = 32'h13000000; fill_size = 2'd0;
      @(negedge clk);
      inv_one = 1'b0; fill_en = 1'b0;
      look("R8 directed flush of entry 3", 32'h91000000, 7'd0, 1'b0, 32'h0);
      look("R9 dropped fill absent",       32'h93000000, 7'd0, 1'b0, 32'h0);
      fill(32'h93000000, 32'h13000000, 2'd0);   // pointer still at entry 5
      look("R9 pointer held, entry 5 evicted", 32'h80000410, 7'd0, 1'b0, 32'h0);
      look("R9 refill lands",                  32'h93000004, 7'd0, 1'b1, 32'h13000004);

      // R8: directed flush removes a pinned entry too
      flush(1'b0, 32'hA0077777);
      look("R8 pinned entry flushed", 32'hA0000000, 7'd0, 1'b0, 32'h0);
      look("R8 other pinned kept",    32'hB001FFFF, 7'd0, 1'b1, 32'h3004FFFF);

      @(negedge clk);
      chk("R4 idle response", 32'(rsp_valid), 32'd0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule